// File: doc/BRIEF.md
# Watch-Mode Power Sequencer

This block tracks the operating mode of a small microcontroller core and steps it between its full-speed, medium-speed and low-speed running modes and three sleep states. When the core issues a sleep strobe, the block decides from a handful of configuration bits whether the core dozes, drops into full standby, or enters watch mode. In watch mode only the timekeeping timer keeps its clock, and the I/O pins are asked to go high-impedance.

Wake-up from watch mode comes from the timekeeping timer interrupt or from either of two external interrupt lines, provided each source is allowed to wake the core. When the core wakes toward a fast mode, a programmable settling wait runs first, counted on the always-running sub-clock. When the wait ends, the clocks are restored and a one-cycle pulse starts interrupt exception handling. The reset pin overrides everything and returns the core to full speed. Real clock generation, retention circuitry and the CPU are outside this block; it drives only enables and status.

Top module: `pmode_ctrl`

## Requirements
- R1: In HIGH, MEDIUM or SUB mode, a sleep strobe with `sby_en`=1, `direct_xfer`=0 and `tmr_ck_sel`=1 moves the mode to WATCH on the next clock edge.
- R2: In a running mode, a sleep strobe with `sby_en`=0 enters SLEEP. With `sby_en`=1 and `tmr_ck_sel`=0 it enters STANDBY. With `sby_en`=1, `tmr_ck_sel`=1 and `direct_xfer`=1 it is ignored and the mode is unchanged.
- R3: The clock enables follow the mode. Running modes enable CPU, peripherals and timer. SLEEP enables peripherals and timer only. WATCH and SETTLE enable the timer only. STANDBY enables nothing.
- R4: `io_hiz` is 1 in WATCH, SETTLE and STANDBY, and 0 in every other mode.
- R5: A wake source is either the timer interrupt with `tmr_ie`=1 and `cpu_mask`=0, or an external line `ext_irq[i]` with `ext_en[i]`=1.
- R6: A wake from WATCH with `low_speed`=1 moves directly to SUB, and `irq_start` is 1 in the same cycle.
- R7: A wake from WATCH with `low_speed`=0 enters SETTLE for exactly N cycles. The mode then becomes HIGH if `mid_speed`=0 or MEDIUM if `mid_speed`=1, as latched at the wake, with `irq_start`=1 in that same cycle.
- R8: The settling length N is 8<<`settle_sel` for codes 0 to 6 (8 up to 512 cycles), and 1 for code 7.
- R9: An external line whose enable is 0, or a timer interrupt with `tmr_ie`=0 or `cpu_mask`=1, leaves WATCH unchanged.
- R10: `rst`=1 forces HIGH on the next edge from any mode, including SETTLE, and drops `irq_start`. Releasing reset produces no `irq_start` pulse.
- R11: The `mode` output encodes HIGH=0, MEDIUM=1, SUB=2, SLEEP=3, STANDBY=4, WATCH=5, SETTLE=6.
- R12: `irq_start` is never high for two consecutive cycles.
- R13: A valid wake in SLEEP goes without settling to SUB (`low_speed`=1), or to HIGH or MEDIUM per `mid_speed`, with an `irq_start` pulse. STANDBY is left only through reset. A sleep strobe outside the running modes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sub-clock |
| rst | input | 1 | Reset pin, synchronous, active high |
| sleep_req | input | 1 | Sleep instruction strobe |
| sby_en | input | 1 | Software standby enable bit |
| direct_xfer | input | 1 | Direct-transfer bit |
| tmr_ck_sel | input | 1 | Timekeeping timer clock-select bit |
| low_speed | input | 1 | Wake into subactive when 1 |
| mid_speed | input | 1 | Wake into medium speed (1) or high speed (0) |
| settle_sel | input | 3 | Settling length code |
| tmr_irq | input | 1 | Timekeeping timer interrupt request |
| tmr_ie | input | 1 | Timer interrupt enable |
| cpu_mask | input | 1 | CPU interrupt mask |
| ext_irq | input | 2 | External interrupt request lines |
| ext_en | input | 2 | Per-line external interrupt enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| tmr_clk_en | output | 1 | Timekeeping timer clock enable |
| io_hiz | output | 1 | Request to tri-state I/O pins |
| mode | output | 3 | Current mode code |
| irq_start | output | 1 | One-cycle start of interrupt handling |

## Verification
A wrong mode register appears on `mode` and on the clock enables in the cycle after the faulty edge, because both are decoded straight from that register. A miscounted settle shows up as SETTLE lasting one or more cycles too long or too short, so the bench measures the exact dwell for several codes, including the one-cycle and 512-cycle extremes. A wrong latched wake target or a misplaced start pulse appears in the cycle SETTLE ends, where the bench compares the target mode and `irq_start` together and then checks that the pulse is gone one cycle later.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    typedef enum logic [2:0] {
        M_HIGH    = 3'd0,
        M_MEDIUM  = 3'd1,
        M_SUB     = 3'd2,
        M_SLEEP   = 3'd3,
        M_STANDBY = 3'd4,
        M_WATCH   = 3'd5,
        M_SETTLE  = 3'd6
    } mode_t;

    typedef struct packed {
        logic       sby_en;
        logic       direct_xfer;
        logic       tmr_ck_sel;
        logic       low_speed;
        logic       mid_speed;
        logic [2:0] settle_sel;
    } cfg_t;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic tmr;
        logic hiz;
    } gate_t;

    function automatic logic is_running(mode_t m);
        return (m == M_HIGH) || (m == M_MEDIUM) || (m == M_SUB);
    endfunction

    // Settling length in sub-clock cycles for a 3-bit code.
    function automatic int unsigned settle_cycles(logic [2:0] code);
        if (code == 3'd7)
            return 1;
        return 32'd8 << code;
    endfunction

    function automatic gate_t gate_of(mode_t m);
        gate_t g;
        case (m)
            M_SLEEP:   g = '{cpu: 1'b0, periph: 1'b1, tmr: 1'b1, hiz: 1'b0};
            M_STANDBY: g = '{cpu: 1'b0, periph: 1'b0, tmr: 1'b0, hiz: 1'b1};
            M_WATCH,
            M_SETTLE:  g = '{cpu: 1'b0, periph: 1'b0, tmr: 1'b1, hiz: 1'b1};
            default:   g = '{cpu: 1'b1, periph: 1'b1, tmr: 1'b1, hiz: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pmode_wake_filter.sv
module pmode_wake_filter #(
    parameter int NUM_EXT = 2
) (
    input  logic               tmr_irq,
    input  logic               tmr_ie,
    input  logic               cpu_mask,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic [NUM_EXT-1:0] ext_en,
    output logic               wake
);
    logic [NUM_EXT-1:0] ext_ok;

    generate
        for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
            assign ext_ok[i] = ext_irq[i] & ext_en[i];
        end
    endgenerate

    // R5 / R9: only enabled, unmasked sources count
    assign wake = (tmr_irq & tmr_ie & ~cpu_mask) | (|ext_ok);
endmodule

// File: rtl/pmode_settle_timer.sv
module pmode_settle_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = run && (cnt_q == CNT_W'(1));

    a_r8_load_nonzero: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q != '0);

    a_r7_count_down: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pmode_seq.sv
module pmode_seq
    import pmode_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  cfg_t             cfg,
    input  logic             wake,
    input  logic             done,
    output mode_t            mode,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             irq_start
);
    mode_t mode_q, mode_d, tgt_q, tgt_d;
    logic  start_q, start_d;
    mode_t fast_tgt;

    assign fast_tgt = cfg.mid_speed ? M_MEDIUM : M_HIGH;
    assign load_val = CNT_W'(settle_cycles(cfg.settle_sel));

    always_comb begin
        mode_d  = mode_q;
        tgt_d   = tgt_q;
        start_d = 1'b0;
        load    = 1'b0;
        case (mode_q)
            M_HIGH, M_MEDIUM, M_SUB: begin
                if (sleep_req) begin
                    if (!cfg.sby_en)
                        mode_d = M_SLEEP;
                    else if (!cfg.tmr_ck_sel)
                        mode_d = M_STANDBY;
                    else if (!cfg.direct_xfer)
                        mode_d = M_WATCH;
                end
            end
            M_SLEEP: begin
                if (wake) begin
                    mode_d  = cfg.low_speed ? M_SUB : fast_tgt;
                    start_d = 1'b1;
                end
            end
            M_WATCH: begin
                if (wake) begin
                    if (cfg.low_speed) begin
                        mode_d  = M_SUB;
                        start_d = 1'b1;
                    end else begin
                        mode_d = M_SETTLE;
                        tgt_d  = fast_tgt;
                        load   = 1'b1;
                    end
                end
            end
            M_SETTLE: begin
                if (done) begin
                    mode_d  = tgt_q;
                    start_d = 1'b1;
                end
            end
            default: ; // STANDBY: left only by reset
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= M_HIGH;
            tgt_q   <= M_HIGH;
            start_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            tgt_q   <= tgt_d;
            start_q <= start_d;
        end
    end

    assign mode      = mode_q;
    assign irq_start = start_q;

    a_r1_watch_entry: assert property (@(posedge clk) disable iff (rst)
        (is_running(mode_q) && sleep_req && cfg.sby_en && !cfg.direct_xfer && cfg.tmr_ck_sel)
        |=> mode_q == M_WATCH);

    a_r9_hold_watch: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_WATCH && !wake) |=> mode_q == M_WATCH);

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    a_r13_standby_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_STANDBY) |=> mode_q == M_STANDBY);
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
    import pmode_pkg::*;
#(
    parameter int NUM_EXT = 2,
    parameter int CNT_W   = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic               sby_en,
    input  logic               direct_xfer,
    input  logic               tmr_ck_sel,
    input  logic               low_speed,
    input  logic               mid_speed,
    input  logic [2:0]         settle_sel,
    input  logic               tmr_irq,
    input  logic               tmr_ie,
    input  logic               cpu_mask,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic [NUM_EXT-1:0] ext_en,
    output logic               cpu_clk_en,
    output logic               periph_clk_en,
    output logic               tmr_clk_en,
    output logic               io_hiz,
    output logic [2:0]         mode,
    output logic               irq_start
);
    cfg_t             cfg;
    mode_t            cur_mode;
    gate_t            gates;
    logic             wake, done, load;
    logic [CNT_W-1:0] load_val;

    assign cfg = '{sby_en: sby_en, direct_xfer: direct_xfer, tmr_ck_sel: tmr_ck_sel,
                   low_speed: low_speed, mid_speed: mid_speed, settle_sel: settle_sel};

    pmode_wake_filter #(.NUM_EXT(NUM_EXT)) u_wake (
        .tmr_irq  (tmr_irq),
        .tmr_ie   (tmr_ie),
        .cpu_mask (cpu_mask),
        .ext_irq  (ext_irq),
        .ext_en   (ext_en),
        .wake     (wake)
    );

    pmode_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .run      (cur_mode == M_SETTLE),
        .done     (done)
    );

    pmode_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .cfg       (cfg),
        .wake      (wake),
        .done      (done),
        .mode      (cur_mode),
        .load      (load),
        .load_val  (load_val),
        .irq_start (irq_start)
    );

    assign gates         = gate_of(cur_mode);
    assign cpu_clk_en    = gates.cpu;
    assign periph_clk_en = gates.periph;
    assign tmr_clk_en    = gates.tmr;
    assign io_hiz        = gates.hiz;
    assign mode          = cur_mode;

    a_r6_start_has_clock: assert property (@(posedge clk) disable iff (rst)
        irq_start |-> cpu_clk_en && !io_hiz);
endmodule

// File: tb/pmode_ctrl_test.sv
`timescale 1ns/1ps
module pmode_ctrl_test;
    logic clk = 0;
    logic rst = 1;
    logic sleep_req = 0, sby_en = 0, direct_xfer = 0, tmr_ck_sel = 0;
    logic low_speed = 0, mid_speed = 0;
    logic [2:0] settle_sel = 0;
    logic tmr_irq = 0, tmr_ie = 0, cpu_mask = 0;
    logic [1:0] ext_irq = 0, ext_en = 0;
    logic cpu_clk_en, periph_clk_en, tmr_clk_en, io_hiz, irq_start;
    logic [2:0] mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    pmode_ctrl uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sby_en(sby_en),
        .direct_xfer(direct_xfer), .tmr_ck_sel(tmr_ck_sel), .low_speed(low_speed),
        .mid_speed(mid_speed), .settle_sel(settle_sel), .tmr_irq(tmr_irq),
        .tmr_ie(tmr_ie), .cpu_mask(cpu_mask), .ext_irq(ext_irq), .ext_en(ext_en),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .tmr_clk_en(tmr_clk_en),
        .io_hiz(io_hiz), .mode(mode), .irq_start(irq_start)
    );

    // Mode codes (R11)
    localparam int HI = 0, MD = 1, SB = 2, SL = 3, ST = 4, WA = 5, SE = 6;

    typedef struct packed {
        logic [2:0]  sts;
        logic        lson;
        logic        med;
        logic [1:0]  src;   // 0 timer, 1 ext0, 2 ext1
        logic [2:0]  fin;
        logic [10:0] len;   // 0: direct to SUB
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{3'd7, 1'b0, 1'b0, 2'd0, 3'd0, 11'd1},
        '{3'd0, 1'b0, 1'b1, 2'd1, 3'd1, 11'd8},
        '{3'd2, 1'b1, 1'b0, 2'd2, 3'd2, 11'd0},
        '{3'd3, 1'b0, 1'b0, 2'd2, 3'd0, 11'd64},
        '{3'd6, 1'b0, 1'b1, 2'd0, 3'd1, 11'd512}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1;
        sleep_req = 0; tmr_irq = 0; ext_irq = 0;
        tick();
        rst = 0;
    endtask

    task automatic gates(input string req, input int c, input int p, input int t, input int h);
        chk({req, " cpu_clk_en"}, int'(cpu_clk_en), c);
        chk({req, " periph_clk_en"}, int'(periph_clk_en), p);
        chk({req, " tmr_clk_en"}, int'(tmr_clk_en), t);
        chk({req, " io_hiz"}, int'(io_hiz), h);
    endtask

    task automatic do_sleep();
        sleep_req = 1; tick(); sleep_req = 0;
    endtask

    task automatic pulse_src(input int src);
        if (src == 0) tmr_irq = 1; else ext_irq[src-1] = 1;
        tick();
        tmr_irq = 0; ext_irq = 0;
    endtask

    task automatic watch_cfg();
        sby_en = 1; direct_xfer = 0; tmr_ck_sel = 1;
        tmr_ie = 1; cpu_mask = 0; ext_en = 2'b11;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        // Reset state
        do_reset();
        chk("R11 reset mode HIGH", int'(mode), HI);
        chk("R10 reset irq_start", int'(irq_start), 0);
        gates("R3 reset", 1, 1, 1, 0);

        // Vector walk: watch entry, wake, settle
        foreach (VEC[i]) begin
            do_reset();
            watch_cfg();
            low_speed = VEC[i].lson; mid_speed = VEC[i].med; settle_sel = VEC[i].sts;
            do_sleep();
            chk("R1 watch entry", int'(mode), WA);
            gates("R3 R4 watch", 0, 1 - 1, 1, 1);
            tick(); tick();
            chk("R9 no wake idle", int'(mode), WA);
            pulse_src(int'(VEC[i].src));
            if (VEC[i].len == 0) begin
                chk("R6 direct SUB", int'(mode), SB);
                chk("R6 start with SUB", int'(irq_start), 1);
            end else begin
                chk("R7 enter SETTLE", int'(mode), SE);
                gates("R3 R4 settle", 0, 0, 1, 1);
                chk("R7 no early start", int'(irq_start), 0);
                n = 1;
                while (mode == 3'(SE) && n < 2000) begin
                    tick();
                    if (mode == 3'(SE)) n++;
                end
                chk("R8 settle length", n, int'(VEC[i].len));
                chk("R7 target mode", int'(mode), int'(VEC[i].fin));
                chk("R7 start pulse", int'(irq_start), 1);
            end
            gates("R3 after wake", 1, 1, 1, 0);
            tick();
            chk("R12 pulse ends", int'(irq_start), 0);
            if (VEC[i].fin == 3'(SB)) begin
                do_sleep();
                chk("R1 watch from SUB", int'(mode), WA);
            end
        end

        // Plain sleep and wake from it
        do_reset();
        sby_en = 0; low_speed = 0; mid_speed = 1; ext_en = 2'b01;
        do_sleep();
        chk("R2 sleep entry", int'(mode), SL);
        gates("R3 sleep", 0, 1, 1, 0);
        pulse_src(2);
        chk("R9 disabled ext1 in sleep", int'(mode), SL);
        pulse_src(1);
        chk("R13 sleep wake MEDIUM", int'(mode), MD);
        chk("R13 sleep wake start", int'(irq_start), 1);
        tick();
        chk("R12 sleep pulse ends", int'(irq_start), 0);

        // Standby: only reset leaves
        do_reset();
        sby_en = 1; tmr_ck_sel = 0; ext_en = 2'b11; tmr_ie = 1;
        do_sleep();
        chk("R2 standby entry", int'(mode), ST);
        gates("R3 R4 standby", 0, 0, 0, 1);
        pulse_src(1);
        pulse_src(0);
        chk("R13 standby ignores irq", int'(mode), ST);
        rst = 1; tick(); rst = 0;
        chk("R10 reset leaves standby", int'(mode), HI);

        // Direct-transfer set: strobe ignored
        watch_cfg(); direct_xfer = 1;
        do_sleep();
        chk("R2 direct_xfer ignored", int'(mode), HI);
        gates("R2 still running", 1, 1, 1, 0);

        // Disabled / masked sources in watch
        do_reset();
        watch_cfg(); low_speed = 1; ext_en = 2'b10; tmr_ie = 0;
        do_sleep();
        pulse_src(1);
        chk("R9 ext0 disabled", int'(mode), WA);
        pulse_src(0);
        chk("R9 timer ie=0", int'(mode), WA);
        tmr_ie = 1; cpu_mask = 1;
        pulse_src(0);
        chk("R9 timer masked", int'(mode), WA);
        sby_en = 0; do_sleep();
        chk("R13 strobe ignored in watch", int'(mode), WA);
        cpu_mask = 0;
        pulse_src(0);
        chk("R5 timer wakes", int'(mode), SB);

        // Reset during SETTLE
        do_reset();
        watch_cfg(); low_speed = 0; settle_sel = 3'd1;
        do_sleep();
        pulse_src(2);
        tick(); tick();
        chk("R7 in settle before reset", int'(mode), SE);
        rst = 1; tick(); rst = 0;
        chk("R10 reset in settle", int'(mode), HI);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (irq_start) n++;
        end
        chk("R10 no start after reset", n, 0);
        chk("R10 stays HIGH", int'(mode), HI);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule